// File: doc/BRIEF.md
# Mesh Sweep Sequencer

This block drives a mesh-evaluating coprocessor over a two-dimensional grid of points. A start write to its control register begins a sweep. The row index runs from zero up to a programmed last row. Inside each row, the column index runs from zero up to a programmed last column. For every point the block does three things in order: it writes the column index and then the row index into two fixed entries of the engine's register file, it pulses a run request so the engine restarts its program at instruction zero, and it waits for the engine to report either an output vector or a stream of executed instructions.

When the engine reports a vector, the block sends the two operands to memory as two 32-bit words through a write-only valid/ready port, each word byte-swapped. The target address comes from the coordinates with a fixed row pitch of 128 points of 8 bytes each, whatever the programmed mesh width. If the engine runs too many instructions without producing a vector, a watchdog abandons that point, sets a sticky error flag and moves on to the next point. At the end of the sweep the block latches the number of points visited and raises a one-cycle interrupt.

The program engine itself is outside this block. It is seen only through the run, abort, step and vector handshake.

Top module: `mesh_sweep_seq`

## Requirements
- R1: After reset, registers 0 (control), 4 (vertex count) and 5 (last write address) read 0, and mem_valid, irq, run_start and run_abort are low.
- R2: Writing a value with bit 0 set to register 0 while idle starts a sweep. Control bit 0 reads 1 from the next cycle until the sweep ends. Every register write made while busy is ignored, including a second start and a new mesh base.
- R3: Points are visited row by row: rows 0 to register 3 (last row), and inside each row, columns 0 to register 2 (last column). For each point, rf_idx 0 is written with the column, then rf_idx 1 is written with the row, then run_start pulses for one cycle.
- R4: The first word of a point goes to register 1 (mesh base) + 8 × (ROW_PITCH × row + column), with ROW_PITCH = 128 by default and independent of the last-column value.
- R5: Operand A is written at that address and operand B at the address + 4. Each is byte-swapped: operand bits 7:0 appear on mem_data bits 31:24, and operand bits 31:24 appear on bits 7:0.
- R6: While mem_valid is high and mem_ready is low, mem_valid, mem_addr and mem_data hold steady. The sequencer advances only on an accepted word.
- R7: After the second word of a point is accepted, register 5 holds the address of that second word.
- R8: If the engine executes WDOG_LIMIT steps after run_start without an output vector, run_abort pulses for one cycle, nothing is written for that point, control bit 1 (error) is set and the sweep continues with the next point. Bit 1 is cleared when the next sweep starts.
- R9: When the last point is finished, register 4 is loaded with (last column + 1) × (last row + 1), including aborted points. irq pulses for exactly one cycle, on the same edge at which control bit 0 falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| rf_we | output | 1 | Coordinate write into the engine register file |
| rf_idx | output | RF_IDX_W | Register file entry being written |
| rf_wdata | output | 32 | Coordinate value |
| run_start | output | 1 | Engine restart at instruction zero |
| run_abort | output | 1 | Engine stop after a watchdog expiry |
| eng_step | input | 1 | Engine executed one instruction |
| eng_vec | input | 1 | Engine issued its output vector |
| eng_opa | input | 32 | First vector operand |
| eng_opb | input | 32 | Second vector operand |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory write accepted |
| mem_addr | output | 32 | Byte address of the word |
| mem_data | output | 32 | Byte-swapped word |
| irq | output | 1 | One-cycle sweep-done pulse |

## Verification
The bench keeps the default coordinate width and the 128-point row pitch. With this pitch, row-to-row address jumps are checked against a mesh much narrower than the pitch. It lowers WDOG_LIMIT to 16, so a hung engine trips the watchdog within a few dozen cycles. That makes it practical to check the abort step count, the skipped write, the sticky flag and its clearing on the next start. A memory model that accepts only every third cycle exercises the held-request behaviour on both words.

// File: rtl/mesh_sweep_seq.sv
module mesh_sweep_seq #(
  parameter int COORD_W    = 7,
  parameter int ROW_PITCH  = 128,
  parameter int WDOG_LIMIT = 2048,
  parameter int RF_IDX_W   = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  output logic                rf_we,
  output logic [RF_IDX_W-1:0] rf_idx,
  output logic [31:0]         rf_wdata,
  output logic                run_start,
  output logic                run_abort,
  input  logic                eng_step,
  input  logic                eng_vec,
  input  logic [31:0]         eng_opa,
  input  logic [31:0]         eng_opb,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic [31:0]         mem_addr,
  output logic [31:0]         mem_data,
  output logic                irq
);
  localparam int WD_W = $clog2(WDOG_LIMIT + 1);
  localparam int VC_W = 2 * COORD_W + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_LDX, S_LDY, S_GO, S_RUN, S_WR0, S_WR1, S_ABORT, S_NEXT
  } st_t;

  st_t                st;
  logic [31:0]        base_q, last_dma_q, va_q, vb_q;
  logic [COORD_W-1:0] lcol_q, lrow_q, col_q, row_q;
  logic [VC_W-1:0]    pts_q, vert_q;
  logic [WD_W-1:0]    wd_q;
  logic               err_q, irq_q;

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  wire        busy      = (st != S_IDLE);
  wire        cfg_ok    = cfg_we && !busy;
  wire        start_req = cfg_ok && (cfg_addr == 3'd0) && cfg_wdata[0];
  wire        row_end   = (col_q == lcol_q);
  wire        last_pt   = row_end && (row_q == lrow_q);
  wire [31:0] pt_idx    = 32'(row_q) * 32'(ROW_PITCH) + 32'(col_q);
  wire [31:0] pt_addr   = base_q + (pt_idx << 3);

  assign rf_we     = (st == S_LDX) || (st == S_LDY);
  assign rf_idx    = (st == S_LDY) ? RF_IDX_W'(1) : '0;
  assign rf_wdata  = (st == S_LDY) ? 32'(row_q) : 32'(col_q);
  assign run_start = (st == S_GO);
  assign run_abort = (st == S_ABORT);
  assign mem_valid = (st == S_WR0) || (st == S_WR1);
  assign mem_addr  = (st == S_WR1) ? pt_addr + 32'd4 : pt_addr;
  assign mem_data  = (st == S_WR1) ? bswap(vb_q) : bswap(va_q);
  assign irq       = irq_q;

  always_comb begin
    case (cfg_addr)
      3'd0:    cfg_rdata = {30'd0, err_q, busy};
      3'd1:    cfg_rdata = base_q;
      3'd2:    cfg_rdata = 32'(lcol_q);
      3'd3:    cfg_rdata = 32'(lrow_q);
      3'd4:    cfg_rdata = 32'(vert_q);
      3'd5:    cfg_rdata = last_dma_q;
      default: cfg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      base_q     <= '0;
      last_dma_q <= '0;
      va_q       <= '0;
      vb_q       <= '0;
      lcol_q     <= '0;
      lrow_q     <= '0;
      col_q      <= '0;
      row_q      <= '0;
      pts_q      <= '0;
      vert_q     <= '0;
      wd_q       <= '0;
      err_q      <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (cfg_ok) begin
        case (cfg_addr)
          3'd1:    base_q <= cfg_wdata;
          3'd2:    lcol_q <= cfg_wdata[COORD_W-1:0];
          3'd3:    lrow_q <= cfg_wdata[COORD_W-1:0];
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (start_req) begin
          col_q <= '0;
          row_q <= '0;
          pts_q <= '0;
          err_q <= 1'b0;
          st    <= S_LDX;
        end
        S_LDX: st <= S_LDY;
        S_LDY: st <= S_GO;
        S_GO: begin
          wd_q <= '0;
          st   <= S_RUN;
        end
        S_RUN: begin
          if (eng_vec) begin
            va_q <= eng_opa;
            vb_q <= eng_opb;
            st   <= S_WR0;
          end else if (eng_step) begin
            if (wd_q == WD_W'(WDOG_LIMIT - 1)) st <= S_ABORT;
            else wd_q <= wd_q + 1'b1;
          end
        end
        S_WR0: if (mem_ready) st <= S_WR1;
        S_WR1: if (mem_ready) begin
          last_dma_q <= pt_addr + 32'd4;
          st         <= S_NEXT;
        end
        S_ABORT: begin
          err_q <= 1'b1;
          st    <= S_NEXT;
        end
        S_NEXT: begin
          pts_q <= pts_q + 1'b1;
          if (last_pt) begin
            vert_q <= pts_q + 1'b1;
            irq_q  <= 1'b1;
            st     <= S_IDLE;
          end else if (row_end) begin
            col_q <= '0;
            row_q <= row_q + 1'b1;
            st    <= S_LDX;
          end else begin
            col_q <= col_q + 1'b1;
            st    <= S_LDX;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mesh_sweep_seq_chk.sv
module mesh_sweep_seq_chk #(
  parameter int WDOG_LIMIT = 2048
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        irq,
  input logic        rf_we,
  input logic        run_start,
  input logic        run_abort,
  input logic        eng_step,
  input logic        eng_vec,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_data
);
  int          steps;
  logic        second;
  logic [31:0] first_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      steps      <= 0;
      second     <= 1'b0;
      first_addr <= '0;
    end else begin
      if (run_start) steps <= 0;
      else if (eng_step && !eng_vec) steps <= steps + 1;
      if (mem_valid && mem_ready) begin
        second <= !second;
        if (!second) first_addr <= mem_addr;
      end
    end
  end

  // R2
  coord_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> busy);

  // R5
  second_word_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && second) |-> (mem_addr == first_addr + 32'd4));

  // R6
  held_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // R8
  abort_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_abort |-> (steps == WDOG_LIMIT));

  // R8
  abort_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_abort |=> !mem_valid);

  // R9
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R9
  irq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && $past(busy)));
endmodule

bind mesh_sweep_seq mesh_sweep_seq_chk #(.WDOG_LIMIT(WDOG_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .rf_we(rf_we),
  .run_start(run_start), .run_abort(run_abort), .eng_step(eng_step),
  .eng_vec(eng_vec), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data)
);

// File: tb/mesh_sweep_seq_tb.sv
`timescale 1ns/1ps
module mesh_sweep_seq_tb;
  localparam int WDL = 16;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic        rf_we, run_start, run_abort;
  logic [6:0]  rf_idx;
  logic [31:0] rf_wdata;
  logic        eng_step = 0, eng_vec = 0;
  logic [31:0] eng_opa = 0, eng_opb = 0;
  logic        mem_valid, mem_ready = 1;
  logic [31:0] mem_addr, mem_data;
  logic        irq;

  mesh_sweep_seq #(.WDOG_LIMIT(WDL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rf_we(rf_we),
    .rf_idx(rf_idx), .rf_wdata(rf_wdata), .run_start(run_start),
    .run_abort(run_abort), .eng_step(eng_step), .eng_vec(eng_vec),
    .eng_opa(eng_opa), .eng_opb(eng_opb), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] opa_of(input int x, input int y);
    return {8'h11, 8'(y), 8'h5A, 8'(x)};
  endfunction
  function automatic logic [31:0] opb_of(input int x, input int y);
    return {8'hC3, 8'(x), 8'(y), 8'h7E};
  endfunction
  function automatic logic [31:0] swap(input logic [31:0] w);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*(3-b) +: 8] = w[8*b +: 8];
    return r;
  endfunction

  // engine, memory and event logs
  int steps_cfg = 2, hx = -1, hy = -1, stall = 0;
  bit hang_en = 0, active = 0, hang_now = 0;
  int left = 0, cx = 0, cy = 0, cyc = 0;
  logic [31:0] w_addr [0:63], w_data [0:63], rf_log [0:63];
  logic [6:0]  rf_ilog [0:63];
  int wn = 0, rn = 0, sn = 0, an = 0, irq_cnt = 0, hang_steps = 0;
  bit irq_busy = 0;

  always @(negedge clk) begin
    cyc++;
    mem_ready = (stall != 0) ? (cyc % 3 == 0) : 1'b1;
    if (mem_valid && mem_ready && wn < 64) begin
      w_addr[wn] = mem_addr; w_data[wn] = mem_data; wn++;
    end
    if (rf_we && rn < 64) begin
      rf_log[rn] = rf_wdata; rf_ilog[rn] = rf_idx; rn++;
      if (rf_idx == 0) cx = int'(rf_wdata); else cy = int'(rf_wdata);
    end
    if (irq) begin irq_cnt++; irq_busy = cfg_rdata[0]; end
    eng_step = 0; eng_vec = 0;
    if (run_abort) begin an++; active = 0; end
    else if (active) begin
      if (hang_now) begin eng_step = 1; hang_steps++; end
      else if (left > 0) begin eng_step = 1; left--; end
      else begin
        eng_vec = 1; eng_opa = opa_of(cx, cy); eng_opb = opb_of(cx, cy); active = 0;
      end
    end
    if (run_start) begin
      sn++; active = 1; left = steps_cfg;
      hang_now = hang_en && cx == hx && cy == hy;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0; cfg_addr = 0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata; cfg_addr = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(!mem_valid && !irq && !run_start && !run_abort, "R1", "outputs idle",
        {28'd0, mem_valid, irq, run_start, run_abort}, 0);
    rd(0, d); chk(d == 0, "R1", "control", d, 0);
    rd(4, d); chk(d == 0, "R1", "vertex count", d, 0);
    rd(5, d); chk(d == 0, "R1", "last write addr", d, 0);
  endtask

  task automatic t_sweep(input string tag, input logic [31:0] base, input int lc,
                         input int lr, input int stl, input bit hang, input int hxx,
                         input int hyy, input bit poke, input bit exp_err);
    logic [31:0] d, exp_last;
    int p, k, t;
    wr(1, base); wr(2, lc); wr(3, lr);
    stall = stl; hang_en = hang; hx = hxx; hy = hyy;
    wn = 0; rn = 0; sn = 0; an = 0; irq_cnt = 0; hang_steps = 0;
    wr(0, 1);
    rd(0, d); chk(d[0] == 1, "R2", {tag, " busy during sweep"}, d, 1);
    if (poke) begin wr(0, 1); wr(1, 32'hDEAD_0000); end
    t = 0;
    while (irq_cnt == 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (60) @(negedge clk);
    chk(irq_cnt == 1, "R9", {tag, " one irq pulse"}, irq_cnt, 1);
    chk(irq_busy == 0, "R9", {tag, " busy low at irq"}, irq_busy, 0);
    chk(sn == (lc+1)*(lr+1), "R3", {tag, " run_start count"}, sn, (lc+1)*(lr+1));
    p = 0; k = 0; exp_last = 0;
    for (int y = 0; y <= lr; y++)
      for (int x = 0; x <= lc; x++) begin
        chk(rf_ilog[2*p] == 0 && rf_log[2*p] == x, "R3", {tag, " column coord"}, rf_log[2*p], x);
        chk(rf_ilog[2*p+1] == 1 && rf_log[2*p+1] == y, "R3", {tag, " row coord"}, rf_log[2*p+1], y);
        p++;
        if (!(hang && x == hxx && y == hyy)) begin
          chk(w_addr[k] == base + 8*(128*y + x), "R4", {tag, " first word addr"},
              w_addr[k], base + 8*(128*y + x));
          chk(w_data[k] == swap(opa_of(x, y)), "R5", {tag, " operand A data"},
              w_data[k], swap(opa_of(x, y)));
          chk(w_addr[k+1] == base + 8*(128*y + x) + 4, "R5", {tag, " second word addr"},
              w_addr[k+1], base + 8*(128*y + x) + 4);
          chk(w_data[k+1] == swap(opb_of(x, y)), "R5", {tag, " operand B data"},
              w_data[k+1], swap(opb_of(x, y)));
          exp_last = base + 8*(128*y + x) + 4;
          k += 2;
        end
      end
    chk(wn == k, "R6", {tag, " accepted word count"}, wn, k);
    rd(5, d); chk(d == exp_last, "R7", {tag, " last write addr"}, d, exp_last);
    rd(4, d); chk(d == (lc+1)*(lr+1), "R9", {tag, " vertex count"}, d, (lc+1)*(lr+1));
    rd(0, d); chk(d == {30'd0, exp_err, 1'b0}, "R8", {tag, " control after sweep"}, d, {30'd0, exp_err, 1'b0});
    if (hang) begin
      chk(an == 1, "R8", {tag, " one abort"}, an, 1);
      chk(hang_steps == WDL, "R8", {tag, " steps before abort"}, hang_steps, WDL);
    end
    hang_en = 0; stall = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_sweep("R2 poke", 32'h4000_0000, 2, 1, 0, 0, 0, 0, 1, 0);
    t_sweep("R6 single stalled", 32'h0001_0010, 0, 0, 1, 0, 0, 0, 0, 0);
    t_sweep("R4 narrow pitch", 32'h0800_0100, 1, 2, 1, 0, 0, 0, 0, 0);
    t_sweep("R8 hang", 32'h2000_0000, 1, 1, 0, 1, 1, 0, 0, 1);
    t_sweep("R8 clear", 32'h2000_0000, 1, 0, 0, 0, 0, 0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule